// File: doc/BRIEF.md
# Colour-Map Palette Controller

This block keeps a colour map of 260 entries, each holding an 8-bit red, green and blue component. Entries 0 to 255 are the normal colours that a pixel pipeline looks up with an 8-bit pixel code. Entries 256 to 259 are overlay colours reserved for a hardware cursor. Entries 258 and 259 drive two dedicated outputs, the cursor background and the cursor foreground.

A host reaches the map through a 32-bit word register port. It first loads a pointer. It then moves the three components of one colour in the order red, green, blue, one access per component, always in the top byte of the word. After the blue access the pointer steps to the next entry on its own, so a whole ramp of colours can be loaded with one pointer write. A second data window uses the low two pointer bits to select an overlay entry. Read data comes back on a response channel that the host can stall.

The request channel follows valid/ready rules. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. A read puts its result on `rsp_data` with `rsp_valid` one cycle after acceptance. The response stays unchanged until a cycle in which `rsp_ready` is high. While a response waits, `req_ready` is low, so no request is taken. Writes produce no response.

Top module: `palette_dac`

## Requirements
- R1: An accepted write at byte offset 0 (address bits [3:2] = 0) loads the colour pointer from data bits [31:24] and returns the component phase to red.
- R2: Accepted writes at offset 4 (address bits [3:2] = 1) store data bits [31:24] into the entry at the pointer: the first into red, the second into green, the third into blue. `pix_rgb` shows an entry as {8'h00, red, green, blue}.
- R3: After the blue access the pointer increases by one modulo 256 and the phase returns to red.
- R4: Accepted writes at offset 12 (address bits [3:2] = 3) follow the same phase and pointer rules as offset 4. They store into overlay entry 256 + pointer[1:0] and leave the normal entries unchanged. Entry 258 appears on `ovl_bg` and entry 259 on `ovl_fg`, both packed as in R2.
- R5: An accepted read, at any offset, returns the current component of the normal entry at the pointer in `rsp_data[31:23+1]`, with zeros in bits [23:0]. Reads walk the same red, green, blue sequence and advance the pointer after blue.
- R6: Reads and writes share a single phase, so a read followed by two data writes reads red and then stores green and blue of the same entry.
- R7: An accepted write at offset 8 (address bits [3:2] = 2) changes no entry, no pointer and no phase.
- R8: After reset, entries 255, 256 and 258 are white (all components 8'hFF) and every other entry is black. The pointer is 0, the phase is red and `rsp_valid` is low.
- R9: A response held with `rsp_ready` low keeps `rsp_valid` high and `rsp_data` stable. `req_ready` stays low meanwhile, so a request presented in that time is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset; bits [3:2] select the register |
| req_wdata | input | 32 | Write data; only bits [31:24] are used |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Host accepts the response |
| rsp_data | output | 32 | Read component in bits [31:24], zeros below |
| pix_idx | input | 8 | Pixel code to look up |
| pix_rgb | output | 32 | Combinational colour for `pix_idx` |
| ovl_bg | output | 32 | Overlay entry 258 |
| ovl_fg | output | 32 | Overlay entry 259 |

## Verification
The bench builds the block with its default parameters: an 8-bit pointer, four overlay entries and 8-bit components. These defaults make pointer wrap from 255 to 0 reachable with only a few accesses. They also put the reset-white entry 255 and both overlay outputs within reach of short directed sequences. Interleaving reads and writes on one entry shows that a single shared phase is in use. A stalled response with a request presented during the stall shows the back-pressure rule.

// File: rtl/pdac_pkg.sv
package pdac_pkg;
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  localparam logic [1:0] SLOT_INDEX   = 2'd0;
  localparam logic [1:0] SLOT_NORMAL  = 2'd1;
  localparam logic [1:0] SLOT_IGNORED = 2'd2;
  localparam logic [1:0] SLOT_OVERLAY = 2'd3;
endpackage

// File: rtl/pdac_seq.sv
module pdac_seq
  import pdac_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int OVL_N = 4,
  localparam int NORMAL_N = 2 ** IDX_W,
  localparam int ENTRIES  = NORMAL_N + OVL_N,
  localparam int ENT_W    = $clog2(ENTRIES),
  localparam int OVL_W    = $clog2(OVL_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             is_write,
  input  logic [1:0]       slot,
  input  logic [IDX_W-1:0] wbyte,
  output logic [IDX_W-1:0] idx,
  output phase_e           phase,
  output logic             wr_en,
  output logic [ENT_W-1:0] wr_entry,
  output logic             rd_en
);
  logic data_slot;
  logic step;
  logic load_ptr;

  assign data_slot = (slot == SLOT_NORMAL) || (slot == SLOT_OVERLAY);
  assign load_ptr  = fire && is_write && (slot == SLOT_INDEX);
  assign wr_en     = fire && is_write && data_slot;
  assign rd_en     = fire && !is_write;
  assign step      = wr_en || rd_en;

  always_comb begin
    if (slot == SLOT_OVERLAY)
      wr_entry = ENT_W'(NORMAL_N) + ENT_W'(idx[OVL_W-1:0]);
    else
      wr_entry = ENT_W'(idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      phase <= PH_RED;
    end else if (load_ptr) begin
      idx   <= wbyte;
      phase <= PH_RED;
    end else if (step) begin
      case (phase)
        PH_RED: phase <= PH_GRN;
        PH_GRN: phase <= PH_BLU;
        default: begin
          phase <= PH_RED;
          idx   <= idx + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/pdac_store.sv
module pdac_store
  import pdac_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int OVL_N  = 4,
  parameter int COMP_W = 8,
  localparam int NORMAL_N = 2 ** IDX_W,
  localparam int ENTRIES  = NORMAL_N + OVL_N,
  localparam int ENT_W    = $clog2(ENTRIES),
  localparam int RGB_W    = 3 * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ENT_W-1:0]  wr_entry,
  input  phase_e            wr_phase,
  input  logic [COMP_W-1:0] wr_byte,
  input  logic [IDX_W-1:0]  rd_idx,
  input  phase_e            rd_phase,
  output logic [COMP_W-1:0] rd_byte,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [RGB_W-1:0]  pix_rgb,
  output logic [RGB_W-1:0]  bg_rgb,
  output logic [RGB_W-1:0]  fg_rgb
);
  logic [RGB_W-1:0] mem [ENTRIES];
  logic [RGB_W-1:0] rd_word;

  function automatic logic [RGB_W-1:0] reset_colour(int e);
    if (e == NORMAL_N - 1 || e == NORMAL_N || e == NORMAL_N + 2)
      return '1;
    return '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) mem[e] <= reset_colour(e);
    end else if (wr_en) begin
      case (wr_phase)
        PH_RED:  mem[wr_entry][RGB_W-1 -: COMP_W]    <= wr_byte;
        PH_GRN:  mem[wr_entry][2*COMP_W-1 -: COMP_W] <= wr_byte;
        default: mem[wr_entry][COMP_W-1:0]           <= wr_byte;
      endcase
    end
  end

  assign rd_word = mem[ENT_W'(rd_idx)];

  always_comb begin
    case (rd_phase)
      PH_RED:  rd_byte = rd_word[RGB_W-1 -: COMP_W];
      PH_GRN:  rd_byte = rd_word[2*COMP_W-1 -: COMP_W];
      default: rd_byte = rd_word[COMP_W-1:0];
    endcase
  end

  assign pix_rgb = mem[ENT_W'(pix_idx)];
  assign bg_rgb  = mem[ENT_W'(NORMAL_N + 2)];
  assign fg_rgb  = mem[ENT_W'(NORMAL_N + 3)];
endmodule

// File: rtl/pdac_rsp.sv
module pdac_rsp #(
  parameter int COMP_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [COMP_W-1:0] byte_in,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              can_take
);
  assign can_take = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= {byte_in, {(DATA_W-COMP_W){1'b0}}};
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/palette_dac.sv
module palette_dac
  import pdac_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int OVL_N  = 4,
  parameter int COMP_W = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  localparam int NORMAL_N = 2 ** IDX_W,
  localparam int ENTRIES  = NORMAL_N + OVL_N,
  localparam int ENT_W    = $clog2(ENTRIES),
  localparam int RGB_W    = 3 * COMP_W,
  localparam int PAD_W    = DATA_W - RGB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [DATA_W-1:0] pix_rgb,
  output logic [DATA_W-1:0] ovl_bg,
  output logic [DATA_W-1:0] ovl_fg
);
  logic              fire;
  logic [1:0]        slot;
  logic [COMP_W-1:0] top_byte;
  logic [IDX_W-1:0]  cur_idx;
  phase_e            cur_phase;
  logic              wr_en;
  logic [ENT_W-1:0]  wr_entry;
  logic              rd_en;
  logic [COMP_W-1:0] rd_byte;
  logic [RGB_W-1:0]  pix_w, bg_w, fg_w;

  assign fire     = req_valid && req_ready;
  assign slot     = req_addr[3:2];
  assign top_byte = req_wdata[DATA_W-1 -: COMP_W];

  pdac_seq #(.IDX_W(IDX_W), .OVL_N(OVL_N)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .is_write (req_write),
    .slot     (slot),
    .wbyte    (req_wdata[DATA_W-1 -: IDX_W]),
    .idx      (cur_idx),
    .phase    (cur_phase),
    .wr_en    (wr_en),
    .wr_entry (wr_entry),
    .rd_en    (rd_en)
  );

  pdac_store #(.IDX_W(IDX_W), .OVL_N(OVL_N), .COMP_W(COMP_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_entry (wr_entry),
    .wr_phase (cur_phase),
    .wr_byte  (top_byte),
    .rd_idx   (cur_idx),
    .rd_phase (cur_phase),
    .rd_byte  (rd_byte),
    .pix_idx  (pix_idx),
    .pix_rgb  (pix_w),
    .bg_rgb   (bg_w),
    .fg_rgb   (fg_w)
  );

  pdac_rsp #(.COMP_W(COMP_W), .DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rd_en),
    .byte_in   (rd_byte),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .can_take  (req_ready)
  );

  assign pix_rgb = {{PAD_W{1'b0}}, pix_w};
  assign ovl_bg  = {{PAD_W{1'b0}}, bg_w};
  assign ovl_fg  = {{PAD_W{1'b0}}, fg_w};
endmodule

// File: rtl/pdac_checker.sv
module pdac_checker
  import pdac_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [IDX_W-1:0]  cur_idx,
  input phase_e            cur_phase
);
  logic acc;
  logic data_acc;
  assign acc      = req_valid && req_ready;
  assign data_acc = acc && (!req_write || req_addr[3:2] == SLOT_NORMAL
                            || req_addr[3:2] == SLOT_OVERLAY);

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write && req_addr[3:2] == SLOT_INDEX |=>
      cur_idx == $past(req_wdata[DATA_W-1 -: IDX_W]) && cur_phase == PH_RED); // R1

  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cur_phase != phase_e'(2'd3)); // R2

  AST_BLUE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc && cur_phase == PH_BLU |=>
      cur_idx == IDX_W'($past(cur_idx) + 1'b1) && cur_phase == PH_RED); // R3

  AST_RSP_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_data[DATA_W-9:0] == '0); // R5

  AST_IGNORED_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write && req_addr[3:2] == SLOT_IGNORED |=>
      $stable(cur_idx) && $stable(cur_phase)); // R7

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R9

  AST_NO_TAKE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R9
endmodule

bind palette_dac pdac_checker #(.IDX_W(IDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .cur_idx   (cur_idx),
  .cur_phase (cur_phase)
);

// File: tb/palette_dac_test.sv
module palette_dac_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic [7:0]  pix_idx = '0;
  logic [31:0] pix_rgb, ovl_bg, ovl_fg;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  palette_dac uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb), .ovl_bg(ovl_bg), .ovl_fg(ovl_fg)
  );

  // vector: {is_read, addr, data, expected read word}
  localparam int NV = 18;
  localparam logic [68:0] VEC [NV] = '{
    {1'b0, 4'h0, 32'h1000_0000, 32'h0},          // R1 pointer 0x10
    {1'b0, 4'h4, 32'h11AB_CDEF, 32'h0},          // R2 red, low bits junk
    {1'b0, 4'h4, 32'h2200_0000, 32'h0},          // R2 green
    {1'b0, 4'h4, 32'h3300_0000, 32'h0},          // R2 blue, R3 step
    {1'b0, 4'h0, 32'h1000_0000, 32'h0},
    {1'b1, 4'h0, 32'h0, 32'h1100_0000},          // R5
    {1'b1, 4'h4, 32'h0, 32'h2200_0000},          // R5
    {1'b1, 4'hC, 32'h0, 32'h3300_0000},          // R5 then R3 step
    {1'b1, 4'h8, 32'h0, 32'h0000_0000},          // R3 entry 0x11 black
    {1'b0, 4'h0, 32'hFF00_0000, 32'h0},
    {1'b1, 4'h0, 32'h0, 32'hFF00_0000},          // R8 entry 255 white; R6
    {1'b0, 4'h4, 32'h4400_0000, 32'h0},          // R6 green of 255
    {1'b0, 4'h4, 32'h5500_0000, 32'h0},          // R6 blue, wraps R3
    {1'b1, 4'h0, 32'h0, 32'h0000_0000},          // R3 wrapped to entry 0
    {1'b0, 4'h0, 32'hFF00_0000, 32'h0},
    {1'b1, 4'h0, 32'h0, 32'hFF00_0000},          // R6
    {1'b1, 4'h0, 32'h0, 32'h4400_0000},          // R6
    {1'b1, 4'h0, 32'h0, 32'h5500_0000}           // R6
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [31:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 4'h4;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, {31'd0, rsp_valid}, 32'd1);
    chk(tag, rsp_data, exp);
  endtask

  task automatic look(input string tag, input logic [7:0] p, input logic [31:0] exp);
    pix_idx = p;
    #1;
    chk(tag, pix_rgb, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R8 req_ready", {31'd0, req_ready}, 32'd1);
    look("R8 entry0", 8'h00, 32'h0000_0000);
    look("R8 entry255", 8'hFF, 32'h00FF_FFFF);
    look("R8 entry7", 8'h07, 32'h0000_0000);
    chk("R8 ovl_bg", ovl_bg, 32'h00FF_FFFF);
    chk("R8 ovl_fg", ovl_fg, 32'h0000_0000);
    rd("R8 pointer zero red", 32'h0000_0000);

    wr(4'h0, 32'h0000_0000);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_write = !VEC[i][68];
      req_addr  = VEC[i][67:64];
      req_wdata = VEC[i][63:32];
      @(negedge clk);
      req_valid = 1'b0;
      if (VEC[i][68]) begin
        chk($sformatf("R5 vector %0d valid", i), {31'd0, rsp_valid}, 32'd1);
        chk($sformatf("R5/R6 vector %0d data", i), rsp_data, VEC[i][31:0]);
      end
    end

    look("R2 entry 0x10", 8'h10, 32'h0011_2233);
    look("R6 entry 0xFF", 8'hFF, 32'h00FF_4455);

    // R4 overlay writes
    wr(4'h0, 32'h0700_0000);
    wr(4'hC, 32'hA100_0000);
    wr(4'hC, 32'hB200_0000);
    wr(4'hC, 32'hC300_0000);
    chk("R4 ovl_fg", ovl_fg, 32'h00A1_B2C3);
    look("R4 normal entry 7 untouched", 8'h07, 32'h0000_0000);
    rd("R4 pointer advanced to 8", 32'h0000_0000);
    wr(4'h0, 32'h0A00_0000);
    wr(4'hC, 32'h0100_0000);
    wr(4'hC, 32'h0200_0000);
    wr(4'hC, 32'h0300_0000);
    chk("R4 ovl_bg", ovl_bg, 32'h0001_0203);
    chk("R4 ovl_fg kept", ovl_fg, 32'h00A1_B2C3);

    // R7 ignored offset between data writes
    wr(4'h0, 32'h1000_0000);
    wr(4'h4, 32'h9900_0000);
    wr(4'h8, 32'hEE00_0000);
    look("R7 after ignored write", 8'h10, 32'h0099_2233);
    wr(4'h4, 32'h7700_0000);
    wr(4'h4, 32'h6600_0000);
    look("R7 sequence intact", 8'h10, 32'h0099_7766);

    // R9 back-pressure
    wr(4'h0, 32'h1000_0000);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 4'h4;
    @(negedge clk);
    req_write = 1'b1; req_addr = 4'h0; req_wdata = 32'h2000_0000;
    chk("R9 valid", {31'd0, rsp_valid}, 32'd1);
    chk("R9 ready low", {31'd0, req_ready}, 32'd0);
    chk("R9 data", rsp_data, 32'h9900_0000);
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    chk("R9 still valid", {31'd0, rsp_valid}, 32'd1);
    chk("R9 data held", rsp_data, 32'h9900_0000);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9 released", {31'd0, rsp_valid}, 32'd0);
    rd("R9 stalled write not taken", 32'h7700_0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule